// File: doc/BRIEF.md
# 8-bit rotate and shift unit

This unit performs the single-operand bit-movement operations of a small 8-bit controller core: four rotates (with and without carry, left and right), an arithmetic right shift, and a nibble swap. It also performs the two instructions that force the carry flag to 0 or to 1. The core hands it an operand byte, the current flag bits and the opcode byte, and pulses a start strobe. One clock later the unit returns the new byte, the new flag bits and a one-cycle done pulse.

The unit decodes the opcode byte itself. Operand fetch and write-back stay in the core. The lowest opcode bit of each rotate, shift or swap pair selects register or indirect-register addressing. The unit does not act on that bit; it registers it and hands it back so the core can route the write-back. An opcode the unit does not own returns the operand and flags unchanged and raises an illegal indication.

Top module: `rot_shift_unit`

## Requirements
- R1: The flag vector is 6 bits wide with carry at bit 5, zero at bit 4, sign at bit 3, overflow at bit 2, decimal-adjust at bit 1 and half-carry at bit 0. After reset, result, flags, done, illegal and indirect all read 0.
- R2: Opcodes 0x90 and 0x91 rotate left: the result is {a[6:0], a[7]} and the new carry is a[7].
- R3: Opcodes 0x10 and 0x11 rotate left through carry: the result is {a[6:0], carry_in} and the new carry is a[7].
- R4: Opcodes 0xE0 and 0xE1 rotate right: the result is {a[0], a[7:1]} and the new carry is a[0].
- R5: Opcodes 0xC0 and 0xC1 rotate right through carry: the result is {carry_in, a[7:1]} and the new carry is a[0].
- R6: Opcodes 0xD0 and 0xD1 shift right arithmetically: the result is {a[7], a[7:1]}, the new carry is a[0], and overflow is forced to 0.
- R7: For every rotate, zero is set exactly when the result is 0x00, sign equals result bit 7, and overflow is set when result bit 7 differs from operand bit 7. SRA and swap set zero and sign the same way. No opcode changes decimal-adjust or half-carry.
- R8: Opcodes 0xF0 and 0xF1 exchange the upper and lower nibbles, update zero and sign, and keep the incoming carry and overflow.
- R9: Opcode 0xCF clears carry and opcode 0xDF sets carry. Both leave the other five flags unchanged and return the operand as the result.
- R10: Any other opcode returns the operand and all six flags unchanged and sets illegal to 1. Every recognised opcode sets illegal to 0.
- R11: Result, flags, illegal and indirect (opcode bit 0) are registered at the clock edge that samples start. Done is high for exactly the following cycle and is low after any edge at which start was low. Starts on consecutive cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch an operation this cycle |
| opcode_i | input | 8 | Opcode byte |
| operand_i | input | 8 | Operand byte |
| flags_i | input | 6 | Incoming flags {C,Z,S,V,D,H} |
| result_o | output | 8 | Result byte |
| flags_o | output | 6 | Outgoing flags {C,Z,S,V,D,H} |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Opcode not handled by this unit |
| indirect_o | output | 1 | Registered opcode bit 0 |

## Verification
Each rotate, the shift and the swap are driven with the operand bytes 0x00, 0x01, 0x80, 0x7F, 0xA5 and 0xFF, with incoming carry at both 0 and 1. Together these separate the end bit that feeds the carry from the bit that wraps around, show whether the incoming carry leaks into a plain rotate, and make overflow and zero both set and clear. The swap and carry opcodes are driven with every flag set and then with every flag clear, which exposes any flag they should keep but overwrite. Illegal opcodes that sit beside legal ones (0x92, 0xEF, 0xF2, 0xCE) check that the decode looks at the full byte. Starts on back-to-back cycles check that each result pairs with its own request.

// File: rtl/rot_shift_unit.sv
module rot_shift_unit #(
  parameter int W  = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [W-1:0]  operand_i,
  input  logic [FW-1:0] flags_i,
  output logic [W-1:0]  result_o,
  output logic [FW-1:0] flags_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          indirect_o
);
  localparam int FC = 5, FZ = 4, FS = 3, FV = 2;

  logic [3:0]    hi;
  logic          pair;
  logic [W-1:0]  a, r;
  logic          cin, cout, vout, legal, upd_zs;
  logic [FW-1:0] f;

  assign hi   = opcode_i[7:4];
  assign pair = (opcode_i[3:1] == 3'b000);
  assign a    = operand_i;
  assign cin  = flags_i[FC];

  always_comb begin
    r      = a;
    cout   = cin;
    vout   = flags_i[FV];
    legal  = 1'b1;
    upd_zs = 1'b1;
    if (pair) begin
      case (hi)
        4'h9: begin r = {a[W-2:0], a[W-1]}; cout = a[W-1]; vout = r[W-1] ^ a[W-1]; end
        4'h1: begin r = {a[W-2:0], cin};    cout = a[W-1]; vout = r[W-1] ^ a[W-1]; end
        4'hE: begin r = {a[0], a[W-1:1]};   cout = a[0];   vout = r[W-1] ^ a[W-1]; end
        4'hC: begin r = {cin, a[W-1:1]};    cout = a[0];   vout = r[W-1] ^ a[W-1]; end
        4'hD: begin r = {a[W-1], a[W-1:1]}; cout = a[0];   vout = 1'b0; end
        4'hF: begin r = {a[W/2-1:0], a[W-1:W/2]}; end
        default: begin legal = 1'b0; upd_zs = 1'b0; end
      endcase
    end else if (opcode_i[3:0] == 4'hF && hi == 4'hC) begin
      cout = 1'b0; upd_zs = 1'b0;
    end else if (opcode_i[3:0] == 4'hF && hi == 4'hD) begin
      cout = 1'b1; upd_zs = 1'b0;
    end else begin
      legal = 1'b0; upd_zs = 1'b0;
    end
  end

  always_comb begin
    f     = flags_i;
    f[FC] = cout;
    f[FV] = vout;
    if (upd_zs) begin
      f[FZ] = (r == '0);
      f[FS] = r[W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o   <= '0;
      flags_o    <= '0;
      done_o     <= 1'b0;
      illegal_o  <= 1'b0;
      indirect_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o   <= r;
        flags_o    <= f;
        illegal_o  <= ~legal;
        indirect_o <= opcode_i[0];
      end
    end
  end

  a_r11_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  a_r7_dh_kept: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> flags_o[1:0] == $past(flags_i[1:0]));
  a_r6_sra_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opcode_i[7:1] == 7'h68) |=> !flags_o[FV]);
  a_r8_swap_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && opcode_i[7:1] == 7'h78) |=>
      flags_o[FC] == $past(flags_i[FC]) && flags_o[FV] == $past(flags_i[FV]));
  a_r9_carry_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (opcode_i == 8'hCF || opcode_i == 8'hDF)) |=>
      flags_o[FC] == $past(opcode_i[4]) && result_o == $past(operand_i));
  a_r10_illegal_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !legal) |=>
      illegal_o && result_o == $past(operand_i) && flags_o == $past(flags_i));
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pair && legal) |=> flags_o[FZ] == (result_o == '0) && flags_o[FS] == result_o[W-1]);
endmodule

// File: tb/test_rot_shift_unit.sv
module test_rot_shift_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] opcode_i = '0, operand_i = '0;
  logic [5:0] flags_i = '0;
  logic [7:0] result_o;
  logic [5:0] flags_o;
  logic       done_o, illegal_o, indirect_o;

  always #10 clk = ~clk;

  rot_shift_unit i_rot_shift_unit (
    .clk, .rst_n, .start_i, .opcode_i, .operand_i, .flags_i,
    .result_o, .flags_o, .done_o, .illegal_o, .indirect_o);

  typedef struct packed {
    logic [7:0] res;
    logic [5:0] fl;
    logic       ill;
    logic       ind;
    logic [7:0] op;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  string tags[$];

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] a, input logic [5:0] f);
    exp_t e;
    logic c;
    logic rot;
    c = f[5];
    rot = 1'b1;
    e.res = a; e.fl = f; e.ill = 1'b0; e.ind = op[0]; e.op = op;
    case (op)
      8'h90, 8'h91: begin e.res = {a[6:0], a[7]}; e.fl[5] = a[7]; end
      8'h10, 8'h11: begin e.res = {a[6:0], c};    e.fl[5] = a[7]; end
      8'hE0, 8'hE1: begin e.res = {a[0], a[7:1]}; e.fl[5] = a[0]; end
      8'hC0, 8'hC1: begin e.res = {c, a[7:1]};    e.fl[5] = a[0]; end
      8'hD0, 8'hD1: begin e.res = {a[7], a[7:1]}; e.fl[5] = a[0]; e.fl[2] = 1'b0; rot = 1'b0; end
      8'hF0, 8'hF1: begin e.res = {a[3:0], a[7:4]}; rot = 1'b0; end
      8'hCF: begin e.fl[5] = 1'b0; return e; end
      8'hDF: begin e.fl[5] = 1'b1; return e; end
      default: begin e.ill = 1'b1; return e; end
    endcase
    e.fl[4] = (e.res == 8'h00);
    e.fl[3] = e.res[7];
    if (rot) e.fl[2] = e.res[7] ^ a[7];
    return e;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] a, input logic [5:0] f, input string tag);
    @(negedge clk);
    opcode_i = op; operand_i = a; flags_i = f; start_i = 1'b1;
    q.push_back(model(op, a, f));
    tags.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      exp_t e;
      string t;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11 done with no request: got done=1 expected 0");
      end else begin
        e = q.pop_front();
        t = tags.pop_front();
        if (result_o !== e.res || flags_o !== e.fl || illegal_o !== e.ill || indirect_o !== e.ind) begin
          errors++;
          $display("FAIL %s op=%h: got res=%h fl=%b ill=%b ind=%b expected res=%h fl=%b ill=%b ind=%b",
                   t, e.op, result_o, flags_o, illegal_o, indirect_o, e.res, e.fl, e.ill, e.ind);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'h01, 8'h80, 8'h7F, 8'hA5, 8'hFF};
    repeat (3) @(negedge clk);
    checks++;
    if (result_o !== 8'h00 || flags_o !== 6'h00 || done_o !== 1'b0 || illegal_o !== 1'b0 || indirect_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got res=%h fl=%b done=%b ill=%b ind=%b expected all 0",
               result_o, flags_o, done_o, illegal_o, indirect_o);
    end
    rst_n = 1'b1;
    idle(2);
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 6; i++) begin
        drive(8'h90, pats[i], {c[0], 5'b00011}, "R2 R7"); idle(1);
        drive(8'h11, pats[i], {c[0], 5'b01000}, "R3 R7"); idle(1);
        drive(8'hE1, pats[i], {c[0], 5'b10111}, "R4 R7"); idle(1);
        drive(8'hC0, pats[i], {c[0], 5'b00100}, "R5 R7"); idle(1);
        drive(8'hD1, pats[i], {c[0], 5'b00111}, "R6"); idle(1);
        drive(8'hF0, pats[i], {c[0], 5'b11111}, "R8"); idle(1);
        drive(8'hF1, pats[i], {c[0], 5'b00000}, "R8"); idle(1);
      end
    end
    drive(8'hCF, 8'h3C, 6'b111111, "R9"); idle(1);
    drive(8'hCF, 8'h00, 6'b000000, "R9"); idle(1);
    drive(8'hDF, 8'h00, 6'b000000, "R9"); idle(1);
    drive(8'hDF, 8'hC3, 6'b111111, "R9"); idle(1);
    drive(8'h92, 8'h5A, 6'b101010, "R10"); idle(1);
    drive(8'hEF, 8'h81, 6'b010101, "R10"); idle(1);
    drive(8'hF2, 8'h0F, 6'b111111, "R10"); idle(1);
    drive(8'hCE, 8'h77, 6'b100001, "R10"); idle(1);
    drive(8'h00, 8'hFF, 6'b011110, "R10"); idle(1);
    drive(8'h91, 8'h80, 6'b000000, "R11 back-to-back");
    drive(8'hE0, 8'h01, 6'b000000, "R11 back-to-back");
    drive(8'h10, 8'h40, 6'b100000, "R11 back-to-back");
    drive(8'h55, 8'h33, 6'b000001, "R11 back-to-back");
    drive(8'hD0, 8'h81, 6'b000100, "R11 back-to-back");
    idle(4);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing done: got %0d outstanding expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule